// File: doc/BRIEF.md
# Multi-level FSK symbol slicer

The block takes a signed, filtered demodulator sample and decides which symbol of a binary, ternary or quaternary frequency-shift alphabet it is. A mode input picks the alphabet. A deviation input gives the nominal symbol amplitude, and all decision thresholds are derived from it. An invert control can negate the sample before the decision is made. The negation is exact, and that includes the most negative input code.

For each sample that arrives with its valid strobe, the block produces a signed level code and a two-bit data field, together with an output valid strobe, exactly one clock later. It sits after the post-demodulation filter and before any clock recovery. Between accepted samples the outputs hold their last decision.

Top module: `fsk_symbol_slicer`

## Requirements
- R1: Binary mode: let s be the sample after the optional inversion. If s >= 0 the result is level +1 with data 2'b01. Otherwise the result is level -1 with data 2'b00.
- R2: Ternary mode: let h = floor(D/2), where D is the unsigned deviation input. If s >= h the result is level +1 with data 2'b01. Otherwise, if s <= -h, the result is level -1 with data 2'b11. Every other s gives level 0 with data 2'b00.
- R3: Quaternary mode thresholds: s >= 2D gives +3. Otherwise s >= 0 gives +1. Otherwise s >= -2D gives -1. Otherwise the result is -3.
- R4: Quaternary data is Gray coded: +3 gives 2'b10, +1 gives 2'b11, -1 gives 2'b01 and -3 gives 2'b00.
- R5: With invert high, s is the exact negation of the input sample. This includes the most negative input code, which becomes a positive value with no wrap.
- R6: The mode code is 0 for binary, 1 for ternary and 2 for quaternary. Code 3 behaves as binary.
- R7: The level output is a 3-bit two's complement number: +3=011, +1=001, 0=000, -1=111, -3=101.
- R8: The output valid goes high one clock after each clock in which the input valid is high, and it is low one clock after each clock in which the input valid is low. The level and data shown with it belong to the sample, mode, deviation and invert values present in that earlier clock.
- R9: When the input valid is low, the level and data outputs keep their values in the next clock, whatever the other inputs do.
- R10: While reset is high at a clock edge, the output valid, level and data all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed filtered demodulator sample |
| mode | input | 2 | Alphabet select (0 binary, 1 ternary, 2 quaternary, 3 binary) |
| invert | input | 1 | Negate the sample before the decision |
| deviation | input | DEV_W | Unsigned nominal symbol amplitude D |
| out_valid | output | 1 | Decision strobe, one clock after in_valid |
| out_level | output | 3 | Signed symbol level |
| out_bits | output | 2 | Data bits for the decided symbol |

## Verification
The inversion and the threshold comparison act on the same sample in the same clock. A wrong sign extension or a wrapped negation would therefore move a sample across a boundary. To provoke this, the bench uses a narrow sample width and sweeps every sample code, including the most negative one, against every deviation, mode and invert setting. It changes mode, deviation and invert on the very clock that carries each sample. The bench judges each decision against a level computed arithmetically from the settings of that clock. It also checks that an idle clock neither raises the valid nor disturbs the held outputs.

// File: rtl/fsk_slicer_pkg.sv
package fsk_slicer_pkg;

    typedef enum logic [1:0] {
        MODE_BIN  = 2'd0,
        MODE_TER  = 2'd1,
        MODE_QUAD = 2'd2,
        MODE_RSVD = 2'd3
    } fsk_mode_e;

    localparam int LVL_W = 3;
    localparam int BITS_W = 2;

    typedef logic signed [LVL_W-1:0] fsk_level_t;

    localparam fsk_level_t LVL_P3 = 3'sd3;
    localparam fsk_level_t LVL_P1 = 3'sd1;
    localparam fsk_level_t LVL_Z  = 3'sd0;
    localparam fsk_level_t LVL_M1 = -3'sd1;
    localparam fsk_level_t LVL_M3 = -3'sd3;

    typedef struct packed {
        fsk_level_t          level;
        logic [BITS_W-1:0]   bits;
    } fsk_sym_t;

    function automatic fsk_sym_t make_bin(input logic positive);
        fsk_sym_t r;
        r.level = positive ? LVL_P1 : LVL_M1;
        r.bits  = positive ? 2'b01 : 2'b00;
        return r;
    endfunction

    function automatic fsk_sym_t make_ter(input logic above, input logic below);
        fsk_sym_t r;
        if (above) begin
            r.level = LVL_P1;
            r.bits  = 2'b01;
        end else if (below) begin
            r.level = LVL_M1;
            r.bits  = 2'b11;
        end else begin
            r.level = LVL_Z;
            r.bits  = 2'b00;
        end
        return r;
    endfunction

    function automatic logic [BITS_W-1:0] gray_dibit(input fsk_level_t lvl);
        logic [BITS_W-1:0] d;
        case (lvl)
            LVL_P3:  d = 2'b10;
            LVL_P1:  d = 2'b11;
            LVL_M1:  d = 2'b01;
            default: d = 2'b00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fsk_polarity.sv
module fsk_polarity #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 14
) (
    input  logic signed [IN_W-1:0]  raw,
    input  logic                    invert,
    output logic signed [OUT_W-1:0] adj
);
    localparam int EXT = OUT_W - IN_W;

    logic signed [OUT_W-1:0] widened;

    // The output is wider than the input, so negating the most negative code stays exact.
    assign widened = {{EXT{raw[IN_W-1]}}, raw};
    assign adj     = invert ? -widened : widened;
endmodule

// File: rtl/fsk_thresholds.sv
module fsk_thresholds #(
    parameter int DEV_W = 10,
    parameter int OUT_W = 14
) (
    input  logic [DEV_W-1:0]        deviation,
    output logic signed [OUT_W-1:0] half_pos,
    output logic signed [OUT_W-1:0] half_neg,
    output logic signed [OUT_W-1:0] twice_pos,
    output logic signed [OUT_W-1:0] twice_neg
);
    localparam int PAD = OUT_W - DEV_W;

    logic signed [OUT_W-1:0] mag;

    assign mag       = $signed({{PAD{1'b0}}, deviation});
    assign half_pos  = mag >>> 1;
    assign half_neg  = -half_pos;
    assign twice_pos = mag <<< 1;
    assign twice_neg = -twice_pos;
endmodule

// File: rtl/fsk_decider.sv
module fsk_decider
    import fsk_slicer_pkg::*;
#(
    parameter int CMP_W = 14
) (
    input  fsk_mode_e               mode,
    input  logic signed [CMP_W-1:0] smp,
    input  logic signed [CMP_W-1:0] half_pos,
    input  logic signed [CMP_W-1:0] half_neg,
    input  logic signed [CMP_W-1:0] twice_pos,
    input  logic signed [CMP_W-1:0] twice_neg,
    output fsk_sym_t                sym
);
    logic     nonneg;
    fsk_sym_t sym_bin, sym_ter, sym_quad;

    assign nonneg = ~smp[CMP_W-1];

    always_comb begin
        sym_bin = make_bin(nonneg);
        sym_ter = make_ter(smp >= half_pos, smp <= half_neg);

        if (smp >= twice_pos)      sym_quad.level = LVL_P3;
        else if (nonneg)           sym_quad.level = LVL_P1;
        else if (smp >= twice_neg) sym_quad.level = LVL_M1;
        else                       sym_quad.level = LVL_M3;
        sym_quad.bits = gray_dibit(sym_quad.level);

        case (mode)
            MODE_TER:  sym = sym_ter;
            MODE_QUAD: sym = sym_quad;
            default:   sym = sym_bin;
        endcase
    end
endmodule

// File: rtl/fsk_symbol_slicer.sv
module fsk_symbol_slicer
    import fsk_slicer_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int DEV_W    = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [1:0]                 mode,
    input  logic                       invert,
    input  logic [DEV_W-1:0]           deviation,
    output logic                       out_valid,
    output logic signed [2:0]          out_level,
    output logic [1:0]                 out_bits
);
    // The width is large enough for the negated sample and for 2*D, each with a sign bit.
    localparam int NEED_S = SAMPLE_W + 1;
    localparam int NEED_D = DEV_W + 2;
    localparam int CMP_W  = ((NEED_S > NEED_D) ? NEED_S : NEED_D) + 1;

    logic signed [CMP_W-1:0] smp_adj;
    logic signed [CMP_W-1:0] th_hp, th_hn, th_tp, th_tn;
    fsk_sym_t                decided, held;
    logic                    vld_q;

    fsk_polarity #(.IN_W(SAMPLE_W), .OUT_W(CMP_W)) u_pol (
        .raw    (in_sample),
        .invert (invert),
        .adj    (smp_adj)
    );

    fsk_thresholds #(.DEV_W(DEV_W), .OUT_W(CMP_W)) u_thr (
        .deviation (deviation),
        .half_pos  (th_hp),
        .half_neg  (th_hn),
        .twice_pos (th_tp),
        .twice_neg (th_tn)
    );

    fsk_decider #(.CMP_W(CMP_W)) u_dec (
        .mode      (fsk_mode_e'(mode)),
        .smp       (smp_adj),
        .half_pos  (th_hp),
        .half_neg  (th_hn),
        .twice_pos (th_tp),
        .twice_neg (th_tn),
        .sym       (decided)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            held  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) held <= decided;
        end
    end

    assign out_valid = vld_q;
    assign out_level = held.level;
    assign out_bits  = held.bits;

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_level) && $stable(out_bits)));

    p_gray_outer_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_level == LVL_P3 || out_level == LVL_M3))
        |-> (out_bits[1] == ~out_level[2] && out_bits[0] == 1'b0));

    p_zero_ternary_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != MODE_TER) |=> (out_level != LVL_Z));

    p_level_legal_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_level != 3'sb100 && out_level != 3'sb010 && out_level != 3'sb110));
endmodule

// File: tb/fsk_symbol_slicer_test.sv
module fsk_symbol_slicer_test;
    localparam int SW = 6;
    localparam int DW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_sample = '0;
    logic [1:0]           mode = 2'd0;
    logic                 invert = 1'b0;
    logic [DW-1:0]        deviation = '0;
    logic                 out_valid;
    logic signed [2:0]    out_level;
    logic [1:0]           out_bits;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fsk_symbol_slicer #(.SAMPLE_W(SW), .DEV_W(DW)) uut (
        .clk, .rst, .in_valid, .in_sample, .mode, .invert, .deviation,
        .out_valid, .out_level, .out_bits
    );

    task automatic check(input string req, input int got_v, input int got_l, input int got_b,
                         input int exp_v, input int exp_l, input int exp_b);
        compared++;
        if (got_v != exp_v || got_l != exp_l || got_b != exp_b) begin
            mismatched++;
            $display("FAIL %s: got valid=%0d level=%0d bits=%0d, expected valid=%0d level=%0d bits=%0d",
                     req, got_v, got_l, got_b, exp_v, exp_l, exp_b);
        end
    endtask

    // Expected decision computed arithmetically from R1..R7
    task automatic expect_sym(input int m, input int inv, input int dev, input int raw,
                              output int lvl, output int bits, output string req);
        int s;
        s = inv ? -raw : raw;
        if (m == 2) begin
            if (s >= 2 * dev)       lvl = 3;
            else if (s >= 0)        lvl = 1;
            else if (s >= -2 * dev) lvl = -1;
            else                    lvl = -3;
            bits = (lvl == 3) ? 2 : (lvl == 1) ? 3 : (lvl == -1) ? 1 : 0;
            req = "R3/R4 quaternary";
        end else if (m == 1) begin
            if (s >= dev / 2)       begin lvl = 1;  bits = 1; end
            else if (s <= -(dev / 2)) begin lvl = -1; bits = 3; end
            else                    begin lvl = 0;  bits = 0; end
            req = "R2 ternary";
        end else begin
            lvl = (s >= 0) ? 1 : -1;
            bits = (s >= 0) ? 1 : 0;
            req = (m == 3) ? "R6 code3 binary" : "R1 binary";
        end
        if (inv) req = {req, " R5 inverted"};
    endtask

    initial begin
        int pend = 0;
        int el = 0, eb = 0;
        int last_l, last_b;
        string ereq;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", out_valid, out_level, out_bits, 0, 0, 0);
        rst = 1'b0;

        // A quiet cycle after reset: valid must stay low (R8)
        @(negedge clk);
        check("R8 idle after reset", out_valid, out_level, out_bits, 0, 0, 0);

        for (int m = 0; m < 4; m++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int d = 0; d < (1 << DW); d++) begin
                    for (int x = -(1 << (SW - 1)); x < (1 << (SW - 1)); x++) begin
                        mode      = 2'(m);
                        invert    = inv[0];
                        deviation = DW'(d);
                        in_sample = SW'(x);
                        in_valid  = 1'b1;
                        if (pend != 0)
                            check({ereq, " R7 R8"}, out_valid, out_level, out_bits, 1, el, eb);
                        expect_sym(m, inv, d, x, el, eb, ereq);
                        pend = 1;
                        @(negedge clk);
                    end
                end
            end
        end
        check({ereq, " R7 R8"}, out_valid, out_level, out_bits, 1, el, eb);

        // Hold: idle cycles with changing inputs must not disturb outputs (R9)
        last_l = out_level;
        last_b = out_bits;
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            mode      = 2'(k);
            invert    = k[0];
            deviation = DW'(3 + k);
            in_sample = SW'(-32 + 19 * k);
            @(negedge clk);
            check("R9 hold / R8 idle", out_valid, out_level, out_bits, 0, last_l, last_b);
        end

        // Reset in mid-stream clears a nonzero state (R10)
        mode = 2'd2; invert = 1'b0; deviation = 4'd1; in_sample = 6'sd20; in_valid = 1'b1;
        @(negedge clk);
        check("R3/R4 before reset", out_valid, out_level, out_bits, 1, 3, 2);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", out_valid, out_level, out_bits, 0, 0, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: got no completion, expected run end");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule